// File: doc/BRIEF.md
# Regular and Injected Conversion Sequencer

This block decides which analog channel an external converter works on next. The regular group is a programmed list of up to 16 channel numbers, walked in list order. The walk follows one of three modes: single (entry 0 only), scan (the whole list) or discontinuous (one entry per trigger). Single and scan may repeat on their own. Each conversion is launched with a one-cycle `start_o` pulse. The pulse carries the channel number and the conversion length in half-clock ticks, which is the channel's own sampling time (never below 5 ticks) plus 25 ticks. The sequencer then waits for `done_i` from the converter.

An injected group of up to four channels takes priority. An injected trigger aborts any regular conversion in flight and runs the injected list. When the injected list is finished, the sequencer restarts the aborted regular channel and the regular walk continues from there. Injected channel sets are written into a two-entry context queue, which accepts writes while conversions run. An injected sequence takes the oldest queued set when it starts. If the queue is empty, it reuses the set it ran last. A write to a full queue is dropped and flagged.

Top module: `conv_sequencer`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after it rises, every output is 0. The injected context after reset is one entry, channel 0.
- R2: Regular conversions use list entries in index order. Entry i is `reg_list_i[4*i+3:4*i]`. The list length is `reg_len_i`+1.
- R3: Single mode (`mode_i`=00): a regular trigger converts entry 0. Its `done_i` gives `reg_eoc_o` and `reg_eos_o` together. With `cont_i`=1, entry 0 restarts in the same cycle.
- R4: Scan mode (`mode_i`=01 or 11): one trigger converts every entry. `reg_eoc_o` pulses after each conversion, and `reg_eos_o` pulses with the last one. With `cont_i`=1, entry 0 restarts in the same cycle as `reg_eos_o`.
- R5: Discontinuous mode (`mode_i`=10): each trigger converts only the next entry. `reg_eos_o` pulses with the last entry, after which the next trigger starts at entry 0. `cont_i` has no effect in this mode.
- R6: `start_o` is a one-cycle pulse, registered one cycle after the input that caused it. `ch_o`, `grp_o` (1 = injected) and `dur_o` are held until the next start. `dur_o` = max(sampling ticks of `ch_o`, 5) + 25. The sampling ticks of channel c are `smp_i[8*c+7:8*c]`.
- R7: An injected trigger while no injected sequence runs starts injected entry 0 at once. This aborts any regular conversion, and a regular `done_i` in that same cycle is discarded. Injected entries are converted in index order, for the context length + 1. Each conversion gives `inj_eoc_o`, and the last also gives `inj_eos_o`.
- R8: In the cycle of `inj_eos_o`, if a regular conversion is owed, the same regular channel is started again with `grp_o`=0.
- R9: `inj_push_i` stores {`inj_len_i`, `inj_list_i`} into a 2-entry FIFO. An injected start pops the oldest entry, or reuses the current context when the FIFO is empty. A push into a full FIFO with no pop in that cycle is dropped, and `ovf_o` pulses in the next cycle.
- R10: A regular trigger is ignored while a regular conversion is owed or an injected sequence runs. An injected trigger is ignored while an injected sequence runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one edge per half converter clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | 00 single, 01/11 scan, 10 discontinuous |
| cont_i | input | 1 | Repeat single/scan sequences automatically |
| reg_len_i | input | 4 | Regular list length minus one |
| reg_list_i | input | 64 | Regular channel list, 4 bits per entry |
| smp_i | input | 128 | Sampling ticks per channel, 8 bits each |
| reg_trig_i | input | 1 | Regular trigger |
| inj_trig_i | input | 1 | Injected trigger |
| inj_push_i | input | 1 | Write injected context into queue |
| inj_len_i | input | 2 | Injected list length minus one |
| inj_list_i | input | 16 | Injected channel list, 4 bits per entry |
| done_i | input | 1 | Converter finished current conversion |
| start_o | output | 1 | Launch conversion |
| ch_o | output | 4 | Channel of the launched conversion |
| dur_o | output | 9 | Conversion length in ticks |
| grp_o | output | 1 | 1 when the conversion is injected |
| reg_eoc_o | output | 1 | Regular conversion finished |
| reg_eos_o | output | 1 | Regular sequence finished |
| inj_eoc_o | output | 1 | Injected conversion finished |
| inj_eos_o | output | 1 | Injected sequence finished |
| ovf_o | output | 1 | Context queue overflow |

## Verification
Each result of this block is due exactly one cycle after the trigger, push or `done_i` that causes it. This holds for strobes, starts, held channel and duration fields and the overflow pulse alike, because each comes from a single register stage. The bench drives inputs on the falling edge and advances its behavioural model by one step with the same inputs. It compares all outputs at the next falling edge, so every expected value lines up with the cycle in which it falls due. The converter is modelled in the bench, which returns `done_i` after the launched duration. An abort is modelled by restarting that count.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;
  typedef enum logic [1:0] {
    MODE_SINGLE = 2'b00,
    MODE_SCAN   = 2'b01,
    MODE_DISC   = 2'b10,
    MODE_SCAN2  = 2'b11
  } seq_mode_e;

  localparam int MIN_SMP_TICKS = 5;   // 2.5 converter clocks
  localparam int CONV_TICKS    = 25;  // 12.5 converter clocks
endpackage

// File: rtl/conv_timing.sv
module conv_timing
  import conv_seq_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int CH_W   = 4,
  parameter int ST_W   = 8,
  parameter int DUR_W  = ST_W + 1
) (
  input  logic [NUM_CH*ST_W-1:0] smp_i,
  input  logic [CH_W-1:0]        ch_i,
  output logic [DUR_W-1:0]       dur_o
);
  logic [ST_W-1:0] smp;
  logic [ST_W-1:0] smp_eff;

  assign smp     = smp_i[int'(ch_i)*ST_W +: ST_W];
  assign smp_eff = (smp < ST_W'(MIN_SMP_TICKS)) ? ST_W'(MIN_SMP_TICKS) : smp;
  assign dur_o   = DUR_W'(smp_eff) + DUR_W'(CONV_TICKS);
endmodule

// File: rtl/inj_ctx_queue.sv
module inj_ctx_queue #(
  parameter int DEPTH = 2,
  parameter int W     = 18,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic         valid_o,
  output logic [W-1:0] data_o,
  output logic         ovf_o
);
  logic [W-1:0]     mem_q [DEPTH];
  logic [W-1:0]     mem_n [DEPTH];
  logic [CNT_W-1:0] cnt_q, cnt_p, cnt_n;
  logic             pop_eff, wr_ok, ovf_n;

  assign valid_o = (cnt_q != '0);
  assign data_o  = mem_q[0];
  assign pop_eff = pop_i && valid_o;
  assign cnt_p   = cnt_q - CNT_W'(pop_eff);
  assign wr_ok   = push_i && (cnt_p < CNT_W'(DEPTH));
  assign ovf_n   = push_i && !wr_ok;
  assign cnt_n   = cnt_p + CNT_W'(wr_ok);

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      if (pop_eff && i < DEPTH - 1) mem_n[i] = mem_q[i+1];
      else                          mem_n[i] = mem_q[i];
      if (wr_ok && CNT_W'(i) == cnt_p) mem_n[i] = data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_o <= 1'b0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      cnt_q <= cnt_n;
      ovf_o <= ovf_n;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_n[i];
    end
  end

  // R9
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));
  // R9
  ovf_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> cnt_q == CNT_W'(DEPTH));
endmodule

// File: rtl/conv_sequencer.sv
module conv_sequencer
  import conv_seq_pkg::*;
#(
  parameter int NUM_CH  = 16,
  parameter int CH_W    = $clog2(NUM_CH),
  parameter int REG_MAX = 16,
  parameter int RLEN_W  = $clog2(REG_MAX),
  parameter int INJ_MAX = 4,
  parameter int ILEN_W  = $clog2(INJ_MAX),
  parameter int ST_W    = 8,
  parameter int DUR_W   = ST_W + 1,
  parameter int Q_DEPTH = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [1:0]               mode_i,
  input  logic                     cont_i,
  input  logic [RLEN_W-1:0]        reg_len_i,
  input  logic [REG_MAX*CH_W-1:0]  reg_list_i,
  input  logic [NUM_CH*ST_W-1:0]   smp_i,
  input  logic                     reg_trig_i,
  input  logic                     inj_trig_i,
  input  logic                     inj_push_i,
  input  logic [ILEN_W-1:0]        inj_len_i,
  input  logic [INJ_MAX*CH_W-1:0]  inj_list_i,
  input  logic                     done_i,
  output logic                     start_o,
  output logic [CH_W-1:0]          ch_o,
  output logic [DUR_W-1:0]         dur_o,
  output logic                     grp_o,
  output logic                     reg_eoc_o,
  output logic                     reg_eos_o,
  output logic                     inj_eoc_o,
  output logic                     inj_eos_o,
  output logic                     ovf_o
);
  localparam int LIST_W = INJ_MAX * CH_W;
  localparam int CTX_W  = LIST_W + ILEN_W;

  logic [CH_W-1:0] reg_ch [REG_MAX];
  for (genvar g = 0; g < REG_MAX; g++) begin : g_unpack
    assign reg_ch[g] = reg_list_i[g*CH_W +: CH_W];
  end

  // sequencing state
  logic              reg_run_q, reg_run_n;   // regular conversion owed
  logic [RLEN_W-1:0] reg_idx_q, reg_idx_n;
  logic              inj_act_q, inj_act_n;
  logic [ILEN_W-1:0] inj_idx_q, inj_idx_n;
  logic              wait_q, wait_n;
  logic [LIST_W-1:0] ctx_list_q, ctx_list_n;
  logic [ILEN_W-1:0] ctx_len_q, ctx_len_n;

  logic              start_n, grp_n, reoc_n, reos_n, ieoc_n, ieos_n;
  logic [CH_W-1:0]   ch_n;
  logic [DUR_W-1:0]  dur_n;
  logic              q_valid, q_pop;
  logic [CTX_W-1:0]  q_data;
  logic              dn, inj_go, reg_last;
  logic [RLEN_W-1:0] reg_nxt;
  logic [ILEN_W-1:0] inj_nxt;

  inj_ctx_queue #(.DEPTH(Q_DEPTH), .W(CTX_W)) u_queue (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (inj_push_i),
    .data_i  ({inj_len_i, inj_list_i}),
    .pop_i   (q_pop),
    .valid_o (q_valid),
    .data_o  (q_data),
    .ovf_o   (ovf_o)
  );

  conv_timing #(.NUM_CH(NUM_CH), .CH_W(CH_W), .ST_W(ST_W), .DUR_W(DUR_W)) u_timing (
    .smp_i (smp_i),
    .ch_i  (ch_n),
    .dur_o (dur_n)
  );

  assign dn       = done_i && wait_q;
  assign inj_go   = inj_trig_i && !inj_act_q;
  assign reg_last = (reg_idx_q == reg_len_i);
  assign reg_nxt  = reg_idx_q + 1'b1;
  assign inj_nxt  = inj_idx_q + 1'b1;

  always_comb begin
    reg_run_n  = reg_run_q;
    reg_idx_n  = reg_idx_q;
    inj_act_n  = inj_act_q;
    inj_idx_n  = inj_idx_q;
    wait_n     = wait_q;
    ctx_list_n = ctx_list_q;
    ctx_len_n  = ctx_len_q;
    start_n    = 1'b0;
    grp_n      = grp_o;
    ch_n       = ch_o;
    reoc_n     = 1'b0;
    reos_n     = 1'b0;
    ieoc_n     = 1'b0;
    ieos_n     = 1'b0;
    q_pop      = 1'b0;
    if (inj_go) begin
      // pre-empt: any regular conversion in flight is dropped
      q_pop     = q_valid;
      if (q_valid) {ctx_len_n, ctx_list_n} = q_data;
      inj_act_n = 1'b1;
      inj_idx_n = '0;
      wait_n    = 1'b1;
      start_n   = 1'b1;
      grp_n     = 1'b1;
      ch_n      = ctx_list_n[CH_W-1:0];
    end else if (dn && inj_act_q) begin
      ieoc_n = 1'b1;
      if (inj_idx_q == ctx_len_q) begin
        ieos_n    = 1'b1;
        inj_act_n = 1'b0;
        if (reg_run_q) begin
          start_n = 1'b1;
          grp_n   = 1'b0;
          ch_n    = reg_ch[reg_idx_q];
        end else begin
          wait_n = 1'b0;
        end
      end else begin
        inj_idx_n = inj_nxt;
        start_n   = 1'b1;
        grp_n     = 1'b1;
        ch_n      = ctx_list_q[int'(inj_nxt)*CH_W +: CH_W];
      end
    end else if (dn) begin
      reoc_n = 1'b1;
      unique case (seq_mode_e'(mode_i))
        MODE_SINGLE: begin
          reos_n = 1'b1;
          if (cont_i) begin
            start_n = 1'b1;
            grp_n   = 1'b0;
            ch_n    = reg_ch[reg_idx_q];
          end else begin
            reg_run_n = 1'b0;
            wait_n    = 1'b0;
          end
        end
        MODE_DISC: begin
          reos_n    = reg_last;
          reg_idx_n = reg_last ? '0 : reg_nxt;
          reg_run_n = 1'b0;
          wait_n    = 1'b0;
        end
        default: begin
          if (reg_last) begin
            reos_n    = 1'b1;
            reg_idx_n = '0;
            if (cont_i) begin
              start_n = 1'b1;
              grp_n   = 1'b0;
              ch_n    = reg_ch[0];
            end else begin
              reg_run_n = 1'b0;
              wait_n    = 1'b0;
            end
          end else begin
            reg_idx_n = reg_nxt;
            start_n   = 1'b1;
            grp_n     = 1'b0;
            ch_n      = reg_ch[reg_nxt];
          end
        end
      endcase
    end else if (reg_trig_i && !reg_run_q && !inj_act_q) begin
      reg_run_n = 1'b1;
      wait_n    = 1'b1;
      start_n   = 1'b1;
      grp_n     = 1'b0;
      ch_n      = reg_ch[reg_idx_q];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reg_run_q  <= 1'b0;
      reg_idx_q  <= '0;
      inj_act_q  <= 1'b0;
      inj_idx_q  <= '0;
      wait_q     <= 1'b0;
      ctx_list_q <= '0;
      ctx_len_q  <= '0;
      start_o    <= 1'b0;
      ch_o       <= '0;
      dur_o      <= '0;
      grp_o      <= 1'b0;
      reg_eoc_o  <= 1'b0;
      reg_eos_o  <= 1'b0;
      inj_eoc_o  <= 1'b0;
      inj_eos_o  <= 1'b0;
    end else begin
      reg_run_q  <= reg_run_n;
      reg_idx_q  <= reg_idx_n;
      inj_act_q  <= inj_act_n;
      inj_idx_q  <= inj_idx_n;
      wait_q     <= wait_n;
      ctx_list_q <= ctx_list_n;
      ctx_len_q  <= ctx_len_n;
      start_o    <= start_n;
      reg_eoc_o  <= reoc_n;
      reg_eos_o  <= reos_n;
      inj_eoc_o  <= ieoc_n;
      inj_eos_o  <= ieos_n;
      if (start_n) begin
        ch_o  <= ch_n;
        grp_o <= grp_n;
        dur_o <= dur_n;
      end
    end
  end

  // R4
  reg_eos_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_eos_o |-> reg_eoc_o);
  // R7
  inj_eos_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inj_eos_o |-> inj_eoc_o);
  // R7
  eoc_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(inj_eoc_o && reg_eoc_o));
  // R8
  resume_grp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inj_eos_o && start_o) |-> !grp_o);
  // R6
  dur_min_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> dur_o >= DUR_W'(MIN_SMP_TICKS + CONV_TICKS));
  // R7
  inj_start_grp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inj_trig_i && !inj_act_q) |=> (start_o && grp_o));
endmodule

// File: tb/tb_conv_sequencer.sv
module tb_conv_sequencer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic        cont = 1'b0;
  logic [3:0]  reg_len = 4'd3;
  logic [63:0] reg_list;
  logic [127:0] smp;
  logic        reg_trig = 1'b0, inj_trig = 1'b0, inj_push = 1'b0, done = 1'b0;
  logic [1:0]  inj_len = '0;
  logic [15:0] inj_list = '0;
  logic        start_o, grp_o, reg_eoc_o, reg_eos_o, inj_eoc_o, inj_eos_o, ovf_o;
  logic [3:0]  ch_o;
  logic [8:0]  dur_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  conv_sequencer dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .cont_i(cont), .reg_len_i(reg_len),
    .reg_list_i(reg_list), .smp_i(smp), .reg_trig_i(reg_trig), .inj_trig_i(inj_trig),
    .inj_push_i(inj_push), .inj_len_i(inj_len), .inj_list_i(inj_list), .done_i(done),
    .start_o(start_o), .ch_o(ch_o), .dur_o(dur_o), .grp_o(grp_o), .reg_eoc_o(reg_eoc_o),
    .reg_eos_o(reg_eos_o), .inj_eoc_o(inj_eoc_o), .inj_eos_o(inj_eos_o), .ovf_o(ovf_o)
  );

  int vectors = 0, miscompares = 0, rem = 0;
  string tag = "R1 reset";
  bit p_rt, p_it, p_pu;
  logic [15:0] p_pl;
  int p_pln;

  // reference model state
  bit m_run, m_inj, m_wait;
  int m_idx, m_iidx, m_clen;
  logic [15:0] m_cl;
  logic [15:0] q_list[$];
  int q_len[$];
  int e_start, e_ch, e_dur, e_grp, e_reoc, e_reos, e_ieoc, e_ieos, e_ovf;

  function automatic int rch(int i); return (i * 5 + 3) % 16; endfunction
  function automatic int smpv(int c); return c * 3; endfunction

  task automatic launch(int g, int c);
    e_start = 1; e_grp = g; e_ch = c; m_wait = 1;
    e_dur = ((smpv(c) < 5) ? 5 : smpv(c)) + 25;
  endtask

  task automatic model_step(bit rt, bit it, bit dn_in, bit pu, logic [15:0] pl, int pln);
    bit dn, pop, last;
    e_start = 0; e_reoc = 0; e_reos = 0; e_ieoc = 0; e_ieos = 0; e_ovf = 0;
    dn = dn_in && m_wait;
    pop = 0;
    last = (m_idx == int'(reg_len));
    if (it && !m_inj) begin
      if (q_list.size() > 0) begin
        pop = 1; m_cl = q_list.pop_front(); m_clen = q_len.pop_front();
      end
      m_inj = 1; m_iidx = 0;
      launch(1, int'(m_cl[3:0]));
    end else if (dn && m_inj) begin
      e_ieoc = 1;
      if (m_iidx == m_clen) begin
        e_ieos = 1; m_inj = 0;
        if (m_run) launch(0, rch(m_idx)); else m_wait = 0;
      end else begin
        m_iidx++;
        launch(1, int'(m_cl[4*m_iidx +: 4]));
      end
    end else if (dn) begin
      e_reoc = 1;
      if (mode == 2'b00) begin
        e_reos = 1;
        if (cont) launch(0, rch(0)); else begin m_run = 0; m_wait = 0; end
      end else if (mode == 2'b10) begin
        if (last) begin e_reos = 1; m_idx = 0; end else m_idx++;
        m_run = 0; m_wait = 0;
      end else if (last) begin
        e_reos = 1; m_idx = 0;
        if (cont) launch(0, rch(0)); else begin m_run = 0; m_wait = 0; end
      end else begin
        m_idx++;
        launch(0, rch(m_idx));
      end
    end else if (rt && !m_run && !m_inj) begin
      m_run = 1;
      launch(0, rch(m_idx));
    end
    if (pu) begin
      if (q_list.size() < 2) begin q_list.push_back(pl); q_len.push_back(pln); end
      else e_ovf = 1;
    end
  endtask

  task automatic chk(string nm, int act, int exp);
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s act=%0d exp=%0d", tag, nm, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    vectors++;
    chk("start_o", int'(start_o), e_start);
    chk("ch_o", int'(ch_o), e_ch);
    chk("grp_o", int'(grp_o), e_grp);
    chk("dur_o(R6)", int'(dur_o), e_dur);
    chk("reg_eoc_o", int'(reg_eoc_o), e_reoc);
    chk("reg_eos_o", int'(reg_eos_o), e_reos);
    chk("inj_eoc_o", int'(inj_eoc_o), e_ieoc);
    chk("inj_eos_o", int'(inj_eos_o), e_ieos);
    chk("ovf_o(R9)", int'(ovf_o), e_ovf);
    // converter model: a new start restarts the count (abort)
    if (start_o) rem = int'(dur_o); else if (rem > 0) rem--;
    done = (rem == 1) && rst_n;
    reg_trig = p_rt; inj_trig = p_it; inj_push = p_pu; inj_list = p_pl; inj_len = 2'(p_pln);
    if (rst_n) model_step(p_rt, p_it, done, p_pu, p_pl, p_pln);
    p_rt = 0; p_it = 0; p_pu = 0;
  endtask

  task automatic run(int n); repeat (n) tick(); endtask
  task automatic rtrig(); p_rt = 1; tick(); endtask
  task automatic itrig(); p_it = 1; tick(); endtask
  task automatic push(logic [15:0] l, int n); p_pu = 1; p_pl = l; p_pln = n; tick(); endtask

  initial begin
    #(CLK_PERIOD * 150000);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      reg_list[4*i +: 4] = 4'(rch(i));
      smp[8*i +: 8] = 8'(smpv(i));
    end
    p_pl = '0; p_pln = 0; m_cl = '0;
    // R1: outputs zero during reset and after release
    run(4);
    rst_n = 1'b1;
    run(2);
    // R2 R3: single one-shot, then continuous
    tag = "R3 single";
    rtrig(); run(60);
    cont = 1; rtrig(); run(120); cont = 0; run(80);
    // R2 R4: scan one-shot with an ignored retrigger (R10)
    tag = "R4 scan / R10";
    mode = 2'b01; rtrig(); run(10); rtrig(); run(250);
    tag = "R4 scan continuous";
    cont = 1; rtrig(); run(320); cont = 0; run(300);
    // R5: discontinuous, cont has no effect
    tag = "R5 disc";
    mode = 2'b10; reg_len = 4'd2; cont = 1;
    for (int k = 0; k < 4; k++) begin rtrig(); run(80); end
    cont = 0;
    // R7 R8: injected pre-empts a scan mid-conversion
    tag = "R7 R8 preempt";
    mode = 2'b01; reg_len = 4'd3;
    push(16'hDB97, 2);
    rtrig(); run(40); itrig(); run(10); itrig(); run(400);
    // R7: injected start while idle, empty queue reuses context
    tag = "R7 R9 idle inject";
    itrig(); run(250);
    // R9: overflow on third push, pop+push while full
    tag = "R9 queue";
    push(16'h0123, 0); push(16'h4567, 1); push(16'h89AB, 3); run(2);
    p_it = 1; p_pu = 1; p_pl = 16'hFEDC; p_pln = 1; tick();
    run(200);
    itrig(); run(200);
    itrig(); run(200);
    tag = "R10 disc during inject";
    mode = 2'b10; reg_len = 4'd1;
    itrig(); rtrig(); run(200);
    rtrig(); run(80); rtrig(); run(80);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule